// File: doc/BRIEF.md
# Circular-Buffer Sequential FIR Engine

This block is an N-tap FIR filter that shares one multiplier and one accumulator across all taps. Input samples land in a ring of N storage slots: each accepted sample overwrites the slot that holds the oldest sample, so nothing is ever shifted. A write pointer wraps modulo N. Coefficients sit in a separate bank, so each cycle can read one coefficient and one stored sample at the same time and perform one multiply-accumulate.

A strobe on `smp_valid_i` starts a run. The engine walks the N taps one per cycle, from the newest sample back to the oldest. It sums the products in an accumulator of 2W + ceil(log2 N) bits. It then emits one rounded and saturated W-bit result with a single-cycle valid pulse. Samples and coefficients are signed two's complement fractions with W-1 fraction bits. Coefficients are loaded through a simple write port whenever the engine is idle.

Top module: `fir_ring_engine`

## Requirements
- R1: After reset, `res_valid_o` and `overrun_o` are 0, `res_data_o` is 0, all coefficients are 0, and all N stored samples are 0, so the first results see only samples accepted after reset.
- R2: Each result equals the sum over k = 0..N-1 of coef[k] times the sample accepted k strobes earlier, with k = 0 the sample that started the run. Only the N most recent accepted samples take part.
- R3: A write with `coef_we_i` = 1 sets coef[`coef_addr_i`] to `coef_data_i`. Coefficient k always pairs with the sample k positions back from the newest.
- R4: Coefficient writes at any of the N+2 rising edges that follow an accepted strobe are ignored and leave all coefficients unchanged.
- R5: `res_valid_o` is high for exactly one cycle. It rises on the (N+2)th rising edge after the edge that accepted the strobe, and at no other time.
- R6: With acc the exact sum of R2, the result is floor((acc + 2^(W-2)) / 2^(W-1)), which is round-half-up of a Q1.(W-1) product sum.
- R7: A rounded value above 2^(W-1)-1 is output as 2^(W-1)-1, and one below -2^(W-1) is output as -2^(W-1).
- R8: A strobe at any of the N+2 rising edges that follow an accepted strobe is dropped. Its sample is never stored and starts no run.
- R9: `overrun_o` goes to 1 on the edge that drops a strobe and stays 1 until reset.
- R10: `res_data_o` keeps its value between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DATA_W | Signed input sample |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | $clog2(TAPS) | Coefficient index (0 pairs with newest sample) |
| coef_data_i | input | DATA_W | Signed coefficient value |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_data_o | output | DATA_W | Rounded, saturated result |
| overrun_o | output | 1 | Sticky dropped-strobe flag |

## Verification
The hardest situations to reach are strobes and coefficient writes that arrive inside a running computation, in particular on the last edges of the busy window. A wrong window length or a lock that ends early changes the result only on a later run. The bench therefore sends strobes and coefficient writes at several offsets into a run, including the edge of the result pulse. A behavioural queue model predicts which of them take effect, and its outputs are compared every cycle. Saturation in both directions is forced with full-scale coefficients and samples.

// File: rtl/fir_ring_pkg.sv
package fir_ring_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_DRAIN = 2'd2,
    PH_EMIT  = 2'd3
  } ph_e;
endpackage

// File: rtl/fir_ring_seq.sv
module fir_ring_seq #(
  parameter int TAPS = 8,
  localparam int TW = $clog2(TAPS),
  localparam int SW = $clog2(TAPS + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  output logic          accept_o,
  output logic          issue_o,
  output logic [TW-1:0] tap_o,
  output logic          emit_o,
  output logic          busy_o,
  output logic          overrun_o
);
  import fir_ring_pkg::*;

  logic          busy_q;
  logic [SW-1:0] step_q;
  logic          ovr_q;
  ph_e           phase;

  always_comb begin
    if (!busy_q)                    phase = PH_IDLE;
    else if (step_q < SW'(TAPS))    phase = PH_ISSUE;
    else if (step_q == SW'(TAPS))   phase = PH_DRAIN;
    else                            phase = PH_EMIT;
  end

  assign accept_o  = smp_valid_i && (phase == PH_IDLE);
  assign issue_o   = (phase == PH_ISSUE);
  assign emit_o    = (phase == PH_EMIT);
  assign busy_o    = busy_q;
  assign tap_o     = step_q[TW-1:0];
  assign overrun_o = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      step_q <= '0;
    end else if (busy_q) begin
      step_q <= step_q + SW'(1);
      if (emit_o) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovr_q <= 1'b0;
    else if (smp_valid_i && busy_q) ovr_q <= 1'b1;
  end

  p_drop_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && busy_q) |=> overrun_o);
  p_overrun_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: rtl/fir_ring_smp.sv
module fir_ring_smp #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  localparam int TW = $clog2(TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic signed [DATA_W-1:0] wr_data_i,
  input  logic                     step_i,
  output logic signed [DATA_W-1:0] rd_data_o
);
  logic signed [DATA_W-1:0] mem_q [TAPS];
  logic [TW-1:0] wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_ptr_q] <= wr_data_i;
      rd_ptr_q        <= wr_ptr_q;  // newest slot is tap 0
      wr_ptr_q        <= (wr_ptr_q == TW'(TAPS - 1)) ? '0 : wr_ptr_q + TW'(1);
    end else if (step_i) begin
      rd_ptr_q <= (rd_ptr_q == '0) ? TW'(TAPS - 1) : rd_ptr_q - TW'(1);
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];

  p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_ptr_q));
endmodule

// File: rtl/fir_ring_coef.sv
module fir_ring_coef #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  localparam int TW = $clog2(TAPS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [TW-1:0]            addr_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic                     lock_i,
  input  logic [TW-1:0]            rd_addr_i,
  output logic signed [DATA_W-1:0] rd_data_o
);
  logic [TAPS-1:0][DATA_W-1:0] coef_q;
  logic [TAPS-1:0]             hit;

  for (genvar i = 0; i < TAPS; i++) begin : g_hit
    assign hit[i] = we_i && !lock_i && (addr_i == TW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
    end else begin
      for (int i = 0; i < TAPS; i++)
        if (hit[i]) coef_q[i] <= data_i;
    end
  end

  assign rd_data_o = coef_q[rd_addr_i];

  p_coef_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(coef_q));
endmodule

// File: rtl/fir_ring_mac.sv
module fir_ring_mac #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  localparam int TW    = $clog2(TAPS),
  localparam int PW    = 2 * DATA_W,
  localparam int ACC_W = PW + TW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     mul_en_i,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic signed [DATA_W-1:0] coef_i,
  input  logic                     emit_i,
  output logic                     res_valid_o,
  output logic signed [DATA_W-1:0] res_data_o
);
  localparam logic signed [ACC_W:0] RND  = {{(ACC_W-DATA_W+2){1'b0}}, 1'b1, {(DATA_W-2){1'b0}}};
  localparam logic signed [ACC_W:0] MAXV = {{(ACC_W-DATA_W+2){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] MINV = {{(ACC_W-DATA_W+2){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0]    prod_q;
  logic                    prod_vld_q;
  logic signed [ACC_W-1:0] acc_q, prod_ext, acc_nxt;
  logic signed [ACC_W:0]   acc_rnd, acc_shr;
  logic signed [DATA_W-1:0] res_nxt;
  logic                    vld_q;
  logic signed [DATA_W-1:0] res_q;

  assign prod_ext = {{(ACC_W-PW){prod_q[PW-1]}}, prod_q};
  assign acc_nxt  = acc_q + prod_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q     <= '0;
      prod_vld_q <= 1'b0;
      acc_q      <= '0;
    end else begin
      prod_vld_q <= mul_en_i;
      if (mul_en_i) prod_q <= PW'(smp_i) * PW'(coef_i);
      if (clr_i)           acc_q <= '0;
      else if (prod_vld_q) acc_q <= acc_nxt;
    end
  end

  // round half up at the Q1.(W-1) point, then clamp
  always_comb begin
    acc_rnd = {acc_q[ACC_W-1], acc_q} + RND;
    acc_shr = acc_rnd >>> (DATA_W - 1);
    if (acc_shr > MAXV)      res_nxt = {1'b0, {(DATA_W-1){1'b1}}};
    else if (acc_shr < MINV) res_nxt = {1'b1, {(DATA_W-1){1'b0}}};
    else                     res_nxt = acc_shr[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= emit_i;
      if (emit_i) res_q <= res_nxt;
    end
  end

  assign res_valid_o = vld_q;
  assign res_data_o  = res_q;

  p_acc_no_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prod_vld_q && !clr_i && (acc_q[ACC_W-1] == prod_ext[ACC_W-1])
      && (acc_nxt[ACC_W-1] != acc_q[ACC_W-1])));
  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> $stable(res_data_o));
endmodule

// File: rtl/fir_ring_engine.sv
module fir_ring_engine #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  localparam int TW = $clog2(TAPS),
  localparam int CW = $clog2(TAPS + 3)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_valid_i,
  input  logic signed [DATA_W-1:0] smp_data_i,
  input  logic                     coef_we_i,
  input  logic [TW-1:0]            coef_addr_i,
  input  logic signed [DATA_W-1:0] coef_data_i,
  output logic                     res_valid_o,
  output logic signed [DATA_W-1:0] res_data_o,
  output logic                     overrun_o
);
  logic          accept, issue, emit, busy;
  logic [TW-1:0] tap;
  logic signed [DATA_W-1:0] smp_rd, coef_rd;

  fir_ring_seq #(.TAPS(TAPS)) u_seq (
    .clk_i, .rst_ni, .smp_valid_i,
    .accept_o(accept), .issue_o(issue), .tap_o(tap),
    .emit_o(emit), .busy_o(busy), .overrun_o
  );

  fir_ring_smp #(.DATA_W(DATA_W), .TAPS(TAPS)) u_smp (
    .clk_i, .rst_ni,
    .wr_en_i(accept), .wr_data_i(smp_data_i),
    .step_i(issue), .rd_data_o(smp_rd)
  );

  fir_ring_coef #(.DATA_W(DATA_W), .TAPS(TAPS)) u_coef (
    .clk_i, .rst_ni,
    .we_i(coef_we_i), .addr_i(coef_addr_i), .data_i(coef_data_i),
    .lock_i(busy), .rd_addr_i(tap), .rd_data_o(coef_rd)
  );

  fir_ring_mac #(.DATA_W(DATA_W), .TAPS(TAPS)) u_mac (
    .clk_i, .rst_ni,
    .clr_i(accept), .mul_en_i(issue),
    .smp_i(smp_rd), .coef_i(coef_rd),
    .emit_i(emit), .res_valid_o, .res_data_o
  );

  // latency tracker seen from the ports only
  logic          trk_on_q;
  logic [CW-1:0] trk_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_on_q  <= 1'b0;
      trk_cnt_q <= '0;
    end else if (!trk_on_q) begin
      if (smp_valid_i) begin
        trk_on_q  <= 1'b1;
        trk_cnt_q <= '0;
      end
    end else begin
      trk_cnt_q <= trk_cnt_q + CW'(1);
      if (trk_cnt_q == CW'(TAPS + 1)) trk_on_q <= 1'b0;
    end
  end

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_on_q && trk_cnt_q == CW'(TAPS + 1)) |=> res_valid_o);
  p_no_early_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trk_on_q && trk_cnt_q == CW'(TAPS + 1)) |=> !res_valid_o);
endmodule

// File: tb/fir_ring_engine_test.sv
module fir_ring_engine_test;
  localparam int W = 16;
  localparam int N = 8;
  localparam int TW = $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [W-1:0] smp_data = '0;
  logic coef_we = 1'b0;
  logic [TW-1:0] coef_addr = '0;
  logic signed [W-1:0] coef_data = '0;
  logic res_valid, overrun;
  logic signed [W-1:0] res_data;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_ring_engine #(.DATA_W(W), .TAPS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_data_i(coef_data),
    .res_valid_o(res_valid), .res_data_o(res_data), .overrun_o(overrun)
  );

  // behavioural reference
  int  hist[$];
  int  coef_m[N];
  bit  m_busy;
  int  m_cnt;
  longint pend;
  logic exp_valid;
  int  exp_data;
  logic exp_ovr;

  function automatic int round_sat(longint a);
    longint r;
    r = (a + (longint'(1) <<< (W-2))) >>> (W-1);
    if (r > (longint'(1) <<< (W-1)) - 1) r = (longint'(1) <<< (W-1)) - 1;
    if (r < -(longint'(1) <<< (W-1)))    r = -(longint'(1) <<< (W-1));
    return int'(r);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < N; i++) begin hist.push_back(0); coef_m[i] = 0; end
      m_busy = 0; m_cnt = 0; pend = 0;
      exp_valid <= 1'b0; exp_data <= 0; exp_ovr <= 1'b0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      exp_valid <= 1'b0;
      if (coef_we && !was_busy) coef_m[coef_addr] = int'(coef_data);
      if (smp_valid && was_busy) exp_ovr <= 1'b1;
      if (was_busy) begin
        if (m_cnt == N + 1) begin
          exp_valid <= 1'b1;
          exp_data  <= round_sat(pend);
          m_busy = 0;
        end else m_cnt++;
      end else if (smp_valid) begin
        hist.push_front(int'(smp_data));
        void'(hist.pop_back());
        pend = 0;
        for (int k = 0; k < N; k++) pend += longint'(coef_m[k]) * longint'(hist[k]);
        m_busy = 1; m_cnt = 0;
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (res_valid !== exp_valid) begin
        errors++;
        $display("FAIL R5 res_valid_o=%0b expected %0b at %0t", res_valid, exp_valid, $time);
      end
      checks++;
      if (int'(res_data) !== exp_data) begin
        errors++;
        $display("FAIL %s (R10) res_data_o=%0d expected %0d at %0t", cur_req, res_data, exp_data, $time);
      end
      checks++;
      if (overrun !== exp_ovr) begin
        errors++;
        $display("FAIL R9 overrun_o=%0b expected %0b at %0t", overrun, exp_ovr, $time);
      end
    end
  end

  task automatic strobe(input int x);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = W'(x);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic run(input int x);
    strobe(x);
    repeat (N + 3) @(negedge clk);
  endtask

  task automatic wr_coef(input int a, input int c);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = TW'(a); coef_data = W'(c);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: zero history after reset
    cur_req = "R1";
    repeat (3) @(negedge clk);
    for (int k = 0; k < N; k++) wr_coef(k, 16384);
    run(1000);
    run(-2000);
    // R3: impulse walks the coefficients in order
    cur_req = "R3";
    for (int k = 0; k < N; k++) wr_coef(k, (k + 1) * 1000 - 3000);
    run(16384);
    for (int i = 0; i < N + 1; i++) run(0);
    // R2: sliding window with random data
    cur_req = "R2";
    for (int k = 0; k < N; k++) wr_coef(k, int'($urandom_range(0, 20000)) - 10000);
    for (int i = 0; i < 3 * N; i++) run(int'($urandom_range(0, 16000)) - 8000);
    // R6: rounding of small sums
    cur_req = "R6";
    for (int k = 0; k < N; k++) wr_coef(k, (k == 0) ? 16384 : 0);
    run(1); run(2); run(3); run(-1); run(-2); run(-3);
    wr_coef(1, 1);
    run(16384); run(16383); run(-16384);
    // R7: saturation both ways
    cur_req = "R7";
    for (int k = 0; k < N; k++) wr_coef(k, 32767);
    for (int i = 0; i < N; i++) run(32767);
    for (int i = 0; i < N; i++) run(-32768);
    for (int k = 0; k < N; k++) wr_coef(k, -32768);
    run(-32768);
    // R4: coefficient writes inside the busy window are ignored
    cur_req = "R4";
    for (int k = 0; k < N; k++) wr_coef(k, 4000 * (k - 3));
    for (int off = 0; off < N + 3; off++) begin
      strobe(int'($urandom_range(0, 10000)) - 5000);
      repeat (off) @(negedge clk);
      coef_we = 1'b1; coef_addr = TW'(off % N); coef_data = W'(off * 777 - 3000);
      @(negedge clk);
      coef_we = 1'b0;
      repeat (N + 3) @(negedge clk);
    end
    run(12345);
    // R8: strobes inside the busy window are dropped
    cur_req = "R8";
    for (int off = 0; off < N + 3; off++) begin
      strobe(1000 + off * 100);
      repeat (off) @(negedge clk);
      strobe(-20000);
      repeat (N + 3) @(negedge clk);
    end
    strobe(500); strobe(600); strobe(700);
    repeat (N + 3) @(negedge clk);
    // R9: flag stays set through idle and further runs
    cur_req = "R9";
    repeat (20) @(negedge clk);
    run(321);
    // R10: output held during long idle
    cur_req = "R10";
    repeat (30) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule